// File: doc/BRIEF.md
# Strobe Sample Aggregator

This block condenses a burst of sampled data-strobe values into a three-way verdict for each of two memory channels. For each channel, the verdict says whether every sampled bit was high, every sampled bit was low, or the samples were a mix of both. A receive-timing calibration routine sets a delay and pulses the channel's start input. It then issues a fixed burst of read operations. For every read beat, it presents the captured strobe lanes on the sample stream. When the channel reports done, the routine reads the two verdict bits of that channel from a shared status word.

Each channel has its own sample stream. A stream is a valid/ready pair carrying `STROBE_W` lanes. Ready is high exactly while that channel is measuring, so the upstream side must hold its beat until ready is seen. A beat counts only on a cycle where valid and ready are both high. Valid may drop between beats at any time. While a channel is idle or done, its ready is low and any beat offered there is never consumed.

The two channels write to disjoint bits of one status word. Channel 1 owns bits 19 (all high) and 18 (all low). Channel 0 owns the same pair moved up by two positions, to bits 21 and 20.

Top module: `strobe_sample_agg`

## Requirements
- R1: While reset is asserted and after its release, `done` is 0, `smp_ready` is 0 and `status` is all zero.
- R2: A start pulse on an idle or done channel clears that channel's done and status bits. In the next cycle, it raises that channel's `smp_ready`.
- R3: If every lane of every accepted beat of a measurement was 1, the channel's all-high bit reads 1 and its all-low bit reads 0 once done.
- R4: If every lane of every accepted beat was 0, the channel's all-low bit reads 1 and its all-high bit reads 0 once done.
- R5: If the accepted beats held at least one 1 and at least one 0, in any lane or beat, both status bits of the channel read 0 once done.
- R6: `done` rises in the cycle after the clock edge that accepts the `BEATS`-th beat (default 56), never earlier. In that same cycle `smp_ready` falls. Done then holds until the next accepted start.
- R7: A beat counts only when `smp_valid` and `smp_ready` are both 1. Cycles with valid low add nothing, and beats offered to a done channel leave its status and done unchanged.
- R8: A start pulse on a channel that is measuring has no effect. The measurement ends after the original `BEATS` beats.
- R9: Channel 1 reports all-high on status bit 19 and all-low on bit 18. Channel 0 reports all-high on bit 21 and all-low on bit 20. Every other status bit is 0.
- R10: The channels are independent: starting and feeding one channel leaves the other channel's done and status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 2 | Per-channel start pulse (bit c = channel c) |
| smp_valid | input | 2 | Per-channel sample beat valid |
| smp_ready | output | 2 | Per-channel sample beat ready (high while measuring) |
| smp_data | input | 2*STROBE_W | Strobe lanes, channel c in bits [c*STROBE_W +: STROBE_W] |
| done | output | 2 | Per-channel measurement complete |
| status | output | 32 | Shared verdict word, layout per R9 |

## Verification
The hardest case to reach is a mixed verdict caused by a single deviating lane in a single beat. A defect in the reduction of one lane, or at one beat position, shows only for that one combination. The bench therefore sweeps every lane against the first beat, a middle beat and the last beat. In each case it drives one channel with one high lane in an otherwise low burst, and the other with one low lane in an otherwise high burst. Idle gaps in valid and a mid-burst start are woven into parts of the sweep, so that counting and restart faults shift the completion cycle where the bench checks it.

// File: rtl/strb_agg_pkg.sv
package strb_agg_pkg;
  localparam int NUM_CH    = 2;
  localparam int STAT_W    = 32;
  localparam int FLAG_BASE = 18;

  typedef struct packed {
    logic all_hi;
    logic all_lo;
  } strb_class_t;

  // lowest status bit owned by channel ch; lower channel index sits higher
  function automatic int flag_pos(input int ch);
    return FLAG_BASE + 2 * (NUM_CH - 1 - ch);
  endfunction

  localparam logic [STAT_W-1:0] USED_MASK =
    STAT_W'(((1 << (2 * NUM_CH)) - 1) << FLAG_BASE);
endpackage

// File: rtl/strb_beat_reduce.sv
module strb_beat_reduce #(
  parameter int W = 8
) (
  input  logic [W-1:0] lanes,
  output logic         beat_hi,
  output logic         beat_lo
);
  logic [W:0] hi_chain;
  logic [W:0] lo_chain;

  assign hi_chain[0] = 1'b1;
  assign lo_chain[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign hi_chain[i+1] = hi_chain[i] & lanes[i];
    assign lo_chain[i+1] = lo_chain[i] & ~lanes[i];
  end

  assign beat_hi = hi_chain[W];
  assign beat_lo = lo_chain[W];
endmodule

// File: rtl/strb_chan.sv
module strb_chan
  import strb_agg_pkg::*;
#(
  parameter int W     = 8,
  parameter int BEATS = 56
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        valid,
  input  logic [W-1:0] lanes,
  output logic        ready,
  output logic        done,
  output strb_class_t res
);
  localparam int CNT_W = $clog2(BEATS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  strb_class_t      run;
  logic             beat_hi, beat_lo;
  logic             take;

  strb_beat_reduce #(.W(W)) u_red (
    .lanes   (lanes),
    .beat_hi (beat_hi),
    .beat_lo (beat_lo)
  );

  assign take  = busy & valid;
  assign ready = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      run  <= '{all_hi: 1'b1, all_lo: 1'b1};
      res  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= '0;
      run  <= '{all_hi: 1'b1, all_lo: 1'b1};
      res  <= '0;
    end else if (take) begin
      cnt        <= cnt + 1'b1;
      run.all_hi <= run.all_hi & beat_hi;
      run.all_lo <= run.all_lo & beat_lo;
      if (cnt == LAST) begin
        busy       <= 1'b0;
        done       <= 1'b1;
        res.all_hi <= run.all_hi & beat_hi;
        res.all_lo <= run.all_lo & beat_lo;
      end
    end
  end
endmodule

// File: rtl/strb_status_pack.sv
module strb_status_pack
  import strb_agg_pkg::*;
(
  input  strb_class_t [NUM_CH-1:0] res,
  output logic [STAT_W-1:0]        status
);
  always_comb begin
    status = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      status[flag_pos(c) + 1] = res[c].all_hi;
      status[flag_pos(c)]     = res[c].all_lo;
    end
  end
endmodule

// File: rtl/strobe_sample_agg.sv
module strobe_sample_agg
  import strb_agg_pkg::*;
#(
  parameter int STROBE_W = 8,
  parameter int BEATS    = 56
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            start,
  input  logic [NUM_CH-1:0]            smp_valid,
  output logic [NUM_CH-1:0]            smp_ready,
  input  logic [NUM_CH*STROBE_W-1:0]   smp_data,
  output logic [NUM_CH-1:0]            done,
  output logic [STAT_W-1:0]            status
);
  strb_class_t [NUM_CH-1:0] res;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    strb_chan #(.W(STROBE_W), .BEATS(BEATS)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start[c]),
      .valid (smp_valid[c]),
      .lanes (smp_data[c*STROBE_W +: STROBE_W]),
      .ready (smp_ready[c]),
      .done  (done[c]),
      .res   (res[c])
    );
  end

  strb_status_pack u_pack (
    .res    (res),
    .status (status)
  );
endmodule

// File: rtl/strobe_sample_agg_chk.sv
module strobe_sample_agg_chk
  import strb_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] start,
  input logic [NUM_CH-1:0] smp_valid,
  input logic [NUM_CH-1:0] smp_ready,
  input logic [NUM_CH-1:0] done,
  input logic [STAT_W-1:0] status
);
  // R9: bits outside the channel pairs never set
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~USED_MASK) == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam int P = flag_pos(c);

    // R6: done rises only after an accepted beat
    p_done_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[c]) |-> $past(smp_valid[c] && smp_ready[c]));

    // R6: a done channel does not accept beats
    p_done_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done[c] && smp_ready[c]));

    // R2: verdict bits stay zero until done
    p_idle_status_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !done[c] |-> status[P+1:P] == 2'b00);

    // R3: both verdicts never together
    p_verdict_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[P+1] && status[P]));

    // R8: start while measuring keeps the channel measuring
    p_restart_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_ready[c] && start[c] && !smp_valid[c]) |=> smp_ready[c]);

    // R7: without start, an idle or done channel keeps its verdict
    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_ready[c] && !start[c]) |=> $stable(status[P+1:P]));
  end
endmodule

bind strobe_sample_agg strobe_sample_agg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .done      (done),
  .status    (status)
);

// File: tb/strobe_sample_agg_test.sv
`timescale 1ns/1ps
module strobe_sample_agg_test;
  localparam int W     = 8;
  localparam int BEATS = 56;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    start = '0;
  logic [1:0]    smp_valid = '0;
  logic [1:0]    smp_ready;
  logic [2*W-1:0] smp_data = '0;
  logic [1:0]    done;
  logic [31:0]   status;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_stat = '0;
  logic [1:0]  exp_done = '0;

  always #2.5 clk = ~clk;

  strobe_sample_agg #(.STROBE_W(W), .BEATS(BEATS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .done(done), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // kinds: 0 all high, 1 all low, 2 high with one low lane at one beat,
  // 3 low with one high lane at one beat, 4 alternating uniform beats
  function automatic logic [W-1:0] gen(input int kind, input int beat, input int lane, input int pos);
    logic [W-1:0] one = W'(1) << lane;
    case (kind)
      0: return '1;
      1: return '0;
      2: return (beat == pos) ? ~one : '1;
      3: return (beat == pos) ? one : '0;
      default: return (beat % 2 == 1) ? '1 : '0;
    endcase
  endfunction

  task automatic run(input logic [1:0] mask, input int k0, input int k1,
                     input int lane, input int pos, input bit gaps, input bit restart);
    logic [1:0] hi = 2'b11, lo = 2'b11;
    for (int b = 0; b < BEATS; b++) begin
      logic [W-1:0] d0 = gen(k0, b, lane, pos);
      logic [W-1:0] d1 = gen(k1, b, lane, pos);
      hi[0] &= &d0;  lo[0] &= ~|d0;
      hi[1] &= &d1;  lo[1] &= ~|d1;
    end
    start = mask;
    @(negedge clk);
    start = '0;
    check("R2 ready after start", 32'(smp_ready & mask), 32'(mask));
    check("R2 done cleared", 32'(done & mask), 0);
    for (int b = 0; b < BEATS; b++) begin
      if (gaps && (b % 7 == 3)) begin
        smp_valid = '0;
        smp_data  = '1;
        @(negedge clk);
      end
      if (b == BEATS - 1)
        check("R6 not done before last beat", 32'(done & mask), 0);
      smp_valid = mask;
      smp_data  = {gen(k1, b, lane, pos), gen(k0, b, lane, pos)};
      if (restart && b == 10) start = mask;
      @(negedge clk);
      start = '0;
    end
    smp_valid = '0;
    for (int c = 0; c < 2; c++) begin
      if (mask[c]) begin
        exp_done[c] = 1'b1;
        exp_stat[21 - 2*c] = hi[c];
        exp_stat[20 - 2*c] = lo[c];
      end
    end
    check("R6 done one cycle after last beat", 32'(done), 32'(exp_done));
    check("R6 ready falls", 32'(smp_ready & mask), 0);
    check("R3 R4 R5 R9 R10 status", status, exp_stat);
    smp_valid = mask;
    smp_data  = {W'(8'h5A), W'(8'hA5)};
    repeat (3) @(negedge clk);
    smp_valid = '0;
    check("R7 stray beats ignored", status, exp_stat);
    check("R7 done held", 32'(done), 32'(exp_done));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset done", 32'(done), 0);
    check("R1 reset ready", 32'(smp_ready), 0);
    check("R1 reset status", status, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {status[29:0], done}, 0);
    run(2'b11, 0, 1, 0, 0, 1'b0, 1'b0);       // R3 ch0 high, R4 ch1 low
    run(2'b11, 1, 0, 0, 0, 1'b1, 1'b1);       // R4 ch0, R3 ch1, R7 gaps, R8
    run(2'b11, 4, 4, 0, 0, 1'b0, 1'b0);       // R5 alternating beats
    for (int lane = 0; lane < W; lane++) begin
      for (int p = 0; p < 3; p++) begin
        int pos = (p == 0) ? 0 : (p == 1) ? 31 : BEATS - 1;
        run(2'b11, 2, 3, lane, pos, lane[0], lane == 2);  // R5 single deviation
        run(2'b11, 3, 2, lane, pos, 1'b0, 1'b0);
      end
    end
    run(2'b01, 0, 0, 0, 0, 1'b1, 1'b0);       // R10 only ch0
    run(2'b10, 1, 1, 0, 0, 1'b0, 1'b1);       // R10 only ch1
    run(2'b01, 1, 0, 0, 0, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule